// File: doc/BRIEF.md
# Quadword Block Copy Channel

This block is one memory-to-memory DMA channel. Software programs a source byte address, a destination offset and a length counted in 16-byte quadwords. It then writes the control register with the start bit set. A copy engine moves the data one 32-bit word at a time over a simple request/acknowledge memory master port: it reads a source word, then writes it to a fixed peripheral base plus the offset. When the last word is written, the block zeroes the count, clears the start bit and posts completion bit 2 in the channel status register.

The status register is 32 bits wide. Its low half holds sixteen status bits: bit 2 is this channel's completion, and the others come from external interrupt sources. Software clears status bits by writing ones to them. The upper half holds an interrupt mask that status writes leave untouched. The DMA interrupt output is high whenever a status bit and its mask bit are both set. This output feeds a processor interrupt input that is separate from the general interrupt controller.

Register word addresses on `reg_addr` are: 0 control, 1 quadword count, 2 source address, 3 destination offset, 4 status, 5 mask. Register reads are combinational and have no side effects.

Top module: `qw_dma_channel`

## Requirements
- R1: After reset every register reads zero, `busy`, `dma_irq` and `mem_req` are low.
- R2: Writing address 0 with bit 0 set while idle copies count×4 words, which is count×16 bytes. Word k is read from source+4k and then written to PERIPH_BASE+offset+4k, in ascending order. Each word needs its own acknowledged read and its own acknowledged write.
- R3: `busy` is high from the cycle after the start write until the transfer ends. `mem_req` is never high while `busy` is low.
- R4: On completion, the count register reads 0, control bit 0 reads 0, and status bit 2 reads 1.
- R5: Starting with a count of zero completes without any memory request and still sets status bit 2.
- R6: While `mem_req` is high and `mem_ack` is low, the request, `mem_we` and `mem_addr` hold in the next cycle, unless a stop is written.
- R7: A write to address 4 clears each status bit [15:0] whose data bit is one and leaves the mask half unchanged. Reading address 4 returns {mask[15:0], status[15:0]}.
- R8: A write to address 5 loads the mask from data bits [15:0].
- R9: `dma_irq` is high exactly when some status bit and its mask bit are both one. It drops once the clearing write removes the last such pair.
- R10: A one-cycle pulse on `src_set[i]` sets status bit i. When a set and a clearing write hit the same bit in the same cycle, the set wins.
- R11: Writing address 0 with bit 0 clear while busy stops the channel. No further memory request is made, completion is not posted, and the count is kept.
- R12: A start write while busy is ignored. The running transfer finishes with exactly its original number of accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| src_set | input | 16 | Status-set pulses from interrupt sources |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` on a read |
| busy | output | 1 | Copy engine active |
| dma_irq | output | 1 | DMA interrupt output |

## Verification
The bench inserts irregular wait states. An engine that advanced without an acknowledge, or that moved its address while waiting, would corrupt the destination or the access count. The bench checks the word just past the last destination word, which catches an off-by-one in the quadword-to-word scaling. A zero count must post completion with no traffic; an engine that wrapped its remaining-word counter would run a huge copy instead. The bench also issues a clearing write and a set pulse on the same bit in the same cycle, stops the channel mid-transfer, and issues a start while the channel is busy. A design that let a clear beat a set, posted completion after a stop, or restarted on a second start would show a wrong status or access count.

// File: rtl/qw_dma_pkg.sv
package qw_dma_pkg;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_COUNT = 3'd1;
    localparam logic [2:0] RA_SRC   = 3'd2;
    localparam logic [2:0] RA_DST   = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
    localparam logic [2:0] RA_MASK  = 3'd5;

    localparam int WORDS_PER_QW = 4;
    localparam int BYTES_PER_WORD = 4;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE,
        ENG_DONE
    } eng_state_e;

endpackage

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import qw_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter logic [AW-1:0] PERIPH_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [CW-1:0] qw_count,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_off,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          done
);
    localparam int RW = CW + 2;

    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [RW-1:0] rem;
        logic [31:0]   data;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.state)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.src = src_addr;
                    eng_d.dst = PERIPH_BASE + dst_off;
                    eng_d.rem = RW'(qw_count) * RW'(WORDS_PER_QW);
                    eng_d.state = (qw_count == '0) ? ENG_DONE : ENG_READ;
                end
            end
            ENG_READ: begin
                if (mem_ack) begin
                    eng_d.data  = mem_rdata;
                    eng_d.state = ENG_WRITE;
                end
            end
            ENG_WRITE: begin
                if (mem_ack) begin
                    eng_d.src = eng_q.src + AW'(BYTES_PER_WORD);
                    eng_d.dst = eng_q.dst + AW'(BYTES_PER_WORD);
                    eng_d.rem = eng_q.rem - 1'b1;
                    eng_d.state = (eng_q.rem == RW'(1)) ? ENG_DONE : ENG_READ;
                end
            end
            ENG_DONE: eng_d.state = ENG_IDLE;
            default:  eng_d.state = ENG_IDLE;
        endcase
        if (abort && (eng_q.state == ENG_READ || eng_q.state == ENG_WRITE)) begin
            eng_d.state = ENG_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: ENG_IDLE, src: '0, dst: '0, rem: '0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mem_req   = (eng_q.state == ENG_READ) || (eng_q.state == ENG_WRITE);
    assign mem_we    = (eng_q.state == ENG_WRITE);
    assign mem_addr  = (eng_q.state == ENG_WRITE) ? eng_q.dst : eng_q.src;
    assign mem_wdata = eng_q.data;
    assign busy      = (eng_q.state != ENG_IDLE);
    assign done      = (eng_q.state == ENG_DONE);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import qw_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    input  logic          busy,
    input  logic          done,
    output logic          start_q,
    output logic [CW-1:0] count_q,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic          start_pulse,
    output logic          stop_pulse
);
    typedef struct packed {
        logic          start;
        logic [CW-1:0] count;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (addr)
                RA_CTRL:  r_d.start = wdata[0];
                RA_COUNT: r_d.count = wdata[CW-1:0];
                RA_SRC:   r_d.src   = wdata[AW-1:0];
                RA_DST:   r_d.dst   = wdata[AW-1:0];
                default:  ;
            endcase
        end
        if (done) begin
            r_d.start = 1'b0;
            r_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_pulse = wr && (addr == RA_CTRL) && wdata[0] && !busy;
    assign stop_pulse  = wr && (addr == RA_CTRL) && !wdata[0];
    assign start_q = r_q.start;
    assign count_q = r_q.count;
    assign src_q   = r_q.src;
    assign dst_q   = r_q.dst;

endmodule

// File: rtl/dma_int_status.sv
module dma_int_status #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_wr,
    input  logic          mask_wr,
    input  logic [SW-1:0] wdata,
    input  logic [SW-1:0] set_vec,
    output logic [SW-1:0] stat_q,
    output logic [SW-1:0] mask_q,
    output logic          irq
);
    typedef struct packed {
        logic [SW-1:0] stat;
        logic [SW-1:0] mask;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_wr) begin
            s_d.stat = s_q.stat & ~wdata;
        end
        if (mask_wr) begin
            s_d.mask = wdata;
        end
        s_d.stat = s_d.stat | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_q = s_q.stat;
    assign mask_q = s_q.mask;
    assign irq    = |(s_q.stat & s_q.mask);

endmodule

// File: rtl/qw_dma_channel.sv
module qw_dma_channel
    import qw_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DONE_BIT = 2,
    parameter logic [AW-1:0] PERIPH_BASE = 32'h1000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [15:0]   src_set,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          dma_irq
);
    localparam int SW = 16;

    logic          start_q, start_pulse, stop_pulse, done;
    logic [CW-1:0] count_q;
    logic [AW-1:0] src_q, dst_q;
    logic [SW-1:0] stat_q, mask_q, set_vec;

    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .done(done), .start_q(start_q), .count_q(count_q),
        .src_q(src_q), .dst_q(dst_q), .start_pulse(start_pulse), .stop_pulse(stop_pulse)
    );

    dma_copy_engine #(.AW(AW), .CW(CW), .PERIPH_BASE(PERIPH_BASE)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .abort(stop_pulse),
        .qw_count(count_q), .src_addr(src_q), .dst_off(dst_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    always_comb begin
        set_vec = src_set;
        set_vec[DONE_BIT] = src_set[DONE_BIT] | done;
    end

    dma_int_status #(.SW(SW)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_wr(reg_wr && reg_addr == RA_STAT),
        .mask_wr(reg_wr && reg_addr == RA_MASK),
        .wdata(reg_wdata[SW-1:0]), .set_vec(set_vec),
        .stat_q(stat_q), .mask_q(mask_q), .irq(dma_irq)
    );

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = {31'b0, start_q};
            RA_COUNT: reg_rdata = 32'(count_q);
            RA_SRC:   reg_rdata = 32'(src_q);
            RA_DST:   reg_rdata = 32'(dst_q);
            RA_STAT:  reg_rdata = {mask_q, stat_q};
            RA_MASK:  reg_rdata = {16'b0, mask_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qw_dma_checker.sv
module qw_dma_checker
    import qw_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DONE_BIT = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [15:0]   src_set,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          busy,
    input logic          done,
    input logic          start_q,
    input logic [CW-1:0] count_q,
    input logic [15:0]   stat_q,
    input logic [15:0]   mask_q
);
    logic stop_wr, clr_wr;
    assign stop_wr = reg_wr && reg_addr == RA_CTRL && !reg_wdata[0];
    assign clr_wr  = reg_wr && reg_addr == RA_STAT;

    // R3: no memory traffic while the engine is idle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6: pending request holds until acknowledged
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: completion zeroes count, clears start and posts the done bit
    a_r4_done_posts: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (count_q == '0 && !start_q && stat_q[DONE_BIT]));

    // R7: write-one-to-clear on the low half, mask half untouched
    a_r7_w1c_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && src_set == '0 && !done) |=>
        (stat_q == ($past(stat_q) & ~$past(reg_wdata[15:0])) && mask_q == $past(mask_q)));

    // R10: a set pulse always lands
    a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((stat_q & $past(src_set)) == $past(src_set)));

endmodule

bind qw_dma_channel qw_dma_checker #(.AW(AW), .CW(CW), .DONE_BIT(DONE_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .src_set(src_set), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .busy(busy), .done(done), .start_q(start_q), .count_q(count_q),
    .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/qw_dma_channel_tb.sv
module qw_dma_channel_tb;
    localparam int AW = 32;
    localparam logic [31:0] BASE = 32'h0000_0800;
    localparam logic [31:0] SRC  = 32'h0000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] src_set = '0;
    logic        mem_req, mem_we, mem_ack, busy, dma_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [2:0] pat = 3'b101;
    logic [31:0] mem [1024];
    logic finished = 1'b0;

    always #2 clk = ~clk;

    qw_dma_channel #(.AW(AW), .PERIPH_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_set(src_set),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .dma_irq(dma_irq)
    );

    assign mem_ack   = mem_req & pat[0];
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        pat <= {pat[0], pat[2:1]};
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    endtask

    task automatic fill();
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 register zero", v, 32'h0);
        end
        chk("R1 busy/irq/req low", {29'b0, busy, dma_irq, mem_req}, 32'h0);
    endtask

    task automatic t_copy(input int qw, input logic [31:0] off);
        logic [31:0] v;
        int r0, w0, words, dbase, sbase;
        fill();
        words = qw * 4;
        dbase = int'((BASE + off) >> 2);
        sbase = int'(SRC >> 2);
        mem[dbase + words] = 32'hDEAD_BEEF;
        r0 = rd_cnt; w0 = wr_cnt;
        wr(3'd2, SRC); wr(3'd3, off); wr(3'd1, 32'(qw)); wr(3'd0, 32'h1);
        chk("R3 busy after start", {31'b0, busy}, 32'h1);
        rd(3'd0, v);
        chk("R3 start bit reads one while running", v, 32'h1);
        wait_idle();
        chk("R2 read count", 32'(rd_cnt - r0), 32'(words));
        chk("R2 write count", 32'(wr_cnt - w0), 32'(words));
        for (int k = 0; k < words; k++)
            chk("R2 destination word", mem[dbase + k], mem[sbase + k]);
        chk("R2 word past end untouched", mem[dbase + words], 32'hDEAD_BEEF);
        rd(3'd1, v); chk("R4 count zeroed", v, 32'h0);
        rd(3'd0, v); chk("R4 start cleared", v, 32'h0);
        rd(3'd4, v); chk("R4 done bit set", v & 32'h4, 32'h4);
        wr(3'd4, 32'h0000_0004);
    endtask

    task automatic t_zero_irq();
        logic [31:0] v;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        wr(3'd5, 32'h0000_0004);
        chk("R9 irq low with nothing pending", {31'b0, dma_irq}, 32'h0);
        wr(3'd1, 32'h0); wr(3'd0, 32'h1);
        repeat (3) @(negedge clk);
        chk("R5 no memory access", 32'(rd_cnt - r0 + wr_cnt - w0), 32'h0);
        rd(3'd4, v); chk("R5 done bit and mask", v, 32'h0004_0004);
        chk("R9 irq high", {31'b0, dma_irq}, 32'h1);
        wr(3'd4, 32'h0000_0004);
        chk("R9 irq drops after clear", {31'b0, dma_irq}, 32'h0);
        rd(3'd4, v); chk("R7 mask kept on status write", v, 32'h0004_0000);
    endtask

    task automatic t_sources();
        logic [31:0] v;
        wr(3'd5, 32'h0000_0010);
        rd(3'd5, v); chk("R8 mask loaded", v, 32'h0000_0010);
        @(negedge clk); src_set = 16'h0018;
        @(negedge clk); src_set = '0;
        rd(3'd4, v); chk("R10 sources set status", v, 32'h0010_0018);
        chk("R9 irq on masked source", {31'b0, dma_irq}, 32'h1);
        wr(3'd4, 32'hFFFF_0010);
        rd(3'd4, v); chk("R7 w1c clears only written bit", v, 32'h0010_0008);
        chk("R9 irq off with unmasked bit left", {31'b0, dma_irq}, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h8; src_set = 16'h0008;
        @(negedge clk);
        reg_wr = 1'b0; src_set = '0;
        rd(3'd4, v); chk("R10 set wins over clear", v, 32'h0010_0008);
        wr(3'd4, 32'h0000_FFFF);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int a0;
        fill();
        wr(3'd1, 32'h8); wr(3'd0, 32'h1);
        for (int i = 0; i < 200 && wr_cnt < 3 + 0; i++) @(negedge clk);
        wr(3'd0, 32'h0);
        a0 = rd_cnt + wr_cnt;
        repeat (30) @(negedge clk);
        chk("R11 no access after stop", 32'(rd_cnt + wr_cnt - a0), 32'h0);
        chk("R11 idle after stop", {31'b0, busy}, 32'h0);
        rd(3'd4, v); chk("R11 no completion posted", v & 32'h4, 32'h0);
        rd(3'd1, v); chk("R11 count kept", v, 32'h8);
    endtask

    task automatic t_restart();
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        wr(3'd1, 32'h2); wr(3'd0, 32'h1);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'h5);
        wr(3'd0, 32'h1);
        wait_idle();
        chk("R12 reads unchanged by second start", 32'(rd_cnt - r0), 32'd8);
        chk("R12 writes unchanged by second start", 32'(wr_cnt - w0), 32'd8);
        wr(3'd4, 32'h0000_FFFF);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        fill();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_copy(1, 32'h0);
        t_copy(3, 32'h0000_0100);
        t_zero_irq();
        t_sources();
        t_stop();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

endmodule